// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block holds the coherence state of every line in one private cache that sits on a shared snooping bus. Each cycle it can take one processor access and one observed bus transaction. For each, it works out the next state of the line concerned. It also says which bus transaction the cache must start, whether a dirty line has to be flushed, and whether this cache must signal that it shares the line being read. Data storage, memory, arbitration and further cache levels lie outside the block.

Every line holds one of four states. Invalid, Shared and Modified form the three-state protocol. Exclusive, a clean private state, is added when the four-state mode is selected. The mode pin is captured while reset is held. A write to a Shared line uses an address-only upgrade instead of a full read-exclusive. The bus is modelled as one transaction per cycle that resolves in the same cycle. The shared response of the other caches arrives on `snp_shared_in` alongside the processor request. State changes of the processor side are named fill-shared, fill-exclusive, fill-modified, upgrade and silent-promote. State changes of the snoop side are named demote-with-flush, demote, kill-with-flush and kill.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: While `rst_n` is low, every line goes to Invalid (state code 0) and `mesi_en` is captured. Changes to `mesi_en` after reset have no effect.
- R2: A processor read to an Invalid line issues a bus read (op code 1). The line fills to Shared (code 1) in three-state mode, or when `snp_shared_in` is high. It fills to Exclusive (code 2) in four-state mode when `snp_shared_in` is low.
- R3: A processor write to an Invalid line issues a read-exclusive (op code 2), and the line becomes Modified (code 3).
- R4: A processor write to a Shared line issues an upgrade (op code 3), and the line becomes Modified.
- R5: A processor write to an Exclusive line becomes Modified with no bus transaction (op code 0).
- R6: Reads that hit Shared, Exclusive or Modified, and writes that hit Modified, issue no bus transaction and leave the state unchanged.
- R7: A snooped bus read (op code 1) demotes a Modified line to Shared and raises `flush_req`. It demotes an Exclusive line to Shared without a flush. It raises `shared_out` whenever the line is valid.
- R8: A snooped read-exclusive (op code 2) invalidates a Modified line and raises `flush_req`. It invalidates Shared and Exclusive lines without a flush.
- R9: A snooped upgrade (op code 3) invalidates a Shared line without a flush. It leaves Modified and Exclusive lines unchanged.
- R10: When a snoop and a processor access target the same line in one cycle, the snoop is applied first. The processor access is then judged against the state the snoop leaves.
- R11: In three-state mode no line ever enters Exclusive.
- R12: When `cpu_valid` is low, `bus_req_op` is 0 and `cpu_new_state` reports the current state of line `cpu_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; lines reset asynchronously, mode captured on clock edges while low |
| mesi_en | input | 1 | 1 selects the four-state mode with Exclusive, 0 the three-state mode |
| cpu_valid | input | 1 | Processor access present |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_idx | input | IDX_W | Line index of the processor access |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_op | input | 2 | Observed transaction: 1 read, 2 read-exclusive, 3 upgrade |
| snp_idx | input | IDX_W | Line index of the observed transaction |
| snp_shared_in | input | 1 | Another cache holds the line being filled |
| bus_req_op | output | 2 | Transaction to issue: 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| flush_req | output | 1 | Dirty line must be written back for the snooped transaction |
| shared_out | output | 1 | This cache holds the line of a snooped read |
| cpu_new_state | output | 2 | State line `cpu_idx` takes after this cycle |

## Verification
The assertions check these behaviours on every cycle: a flush appears only for a snooped read or read-exclusive, an upgrade appears only on a processor write, the bus stays quiet without a processor access, every write ends in Modified, and three-state mode never shows Exclusive. Only the bench's scenarios can show the history-dependent behaviour. This covers the fill state chosen from the shared response and the demotions and kills seen through later accesses. It also covers the ordering when a snoop and an access meet on one line, and the fact that the mode pin is ignored after reset.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_t;
endpackage

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
    import coh_pkg::*;
(
    input  logic        valid,
    input  bus_op_t     op,
    input  line_state_t cur,
    output line_state_t nxt,
    output logic        flush,
    output logic        shared
);
    always_comb begin
        nxt    = cur;
        flush  = 1'b0;
        shared = 1'b0;
        if (valid) begin
            unique case (cur)
                ST_INV: ;
                ST_SHR: begin
                    if (op == BUS_RD) shared = 1'b1;
                    if (op == BUS_RDX || op == BUS_UPG) nxt = ST_INV;  // kill
                end
                ST_EXC: begin
                    if (op == BUS_RD) begin                             // demote
                        shared = 1'b1;
                        nxt    = ST_SHR;
                    end
                    if (op == BUS_RDX) nxt = ST_INV;                    // kill
                end
                ST_MOD: begin
                    if (op == BUS_RD) begin                             // demote-with-flush
                        shared = 1'b1;
                        flush  = 1'b1;
                        nxt    = ST_SHR;
                    end
                    if (op == BUS_RDX) begin                            // kill-with-flush
                        flush = 1'b1;
                        nxt   = ST_INV;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
    import coh_pkg::*;
(
    input  logic        valid,
    input  logic        write,
    input  logic        mesi,
    input  logic        shared_in,
    input  line_state_t cur,
    output line_state_t nxt,
    output bus_op_t     op
);
    always_comb begin
        nxt = cur;
        op  = BUS_NONE;
        if (valid) begin
            unique case (cur)
                ST_INV: begin
                    if (write) begin                 // fill-modified
                        op  = BUS_RDX;
                        nxt = ST_MOD;
                    end else begin                   // fill-shared / fill-exclusive
                        op  = BUS_RD;
                        nxt = (mesi && !shared_in) ? ST_EXC : ST_SHR;
                    end
                end
                ST_SHR: begin
                    if (write) begin                 // upgrade
                        op  = BUS_UPG;
                        nxt = ST_MOD;
                    end
                end
                ST_EXC: begin
                    if (write) nxt = ST_MOD;         // silent-promote
                end
                ST_MOD: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          snp_we,
    input  logic [IDX_W-1:0]              snp_idx,
    input  line_state_t                   snp_nxt,
    input  logic                          cpu_we,
    input  logic [IDX_W-1:0]              cpu_idx,
    input  line_state_t                   cpu_nxt,
    output line_state_t [NUM_LINES-1:0]   lines_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_state_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= ST_INV;
            else if (cpu_we && cpu_idx == IDX_W'(g))
                q <= cpu_nxt;
            else if (snp_we && snp_idx == IDX_W'(g))
                q <= snp_nxt;
        end
        assign lines_o[g] = q;
    end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mesi_en,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             snp_shared_in,
    output logic [1:0]       bus_req_op,
    output logic             flush_req,
    output logic             shared_out,
    output logic [1:0]       cpu_new_state
);
    line_state_t [NUM_LINES-1:0] lines;
    line_state_t snp_cur, snp_nxt, cpu_base, cpu_nxt;
    bus_op_t     cpu_op;
    logic        mesi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) mesi_q <= mesi_en;
    end

    assign snp_cur  = lines[snp_idx];
    assign cpu_base = (snp_valid && snp_idx == cpu_idx) ? snp_nxt : lines[cpu_idx];

    coh_snoop_fsm i_snoop (
        .valid  (snp_valid),
        .op     (bus_op_t'(snp_op)),
        .cur    (snp_cur),
        .nxt    (snp_nxt),
        .flush  (flush_req),
        .shared (shared_out)
    );

    coh_cpu_fsm i_cpu (
        .valid     (cpu_valid),
        .write     (cpu_write),
        .mesi      (mesi_q),
        .shared_in (snp_shared_in),
        .cur       (cpu_base),
        .nxt       (cpu_nxt),
        .op        (cpu_op)
    );

    coh_line_store #(.NUM_LINES(NUM_LINES)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_we  (snp_valid),
        .snp_idx (snp_idx),
        .snp_nxt (snp_nxt),
        .cpu_we  (cpu_valid),
        .cpu_idx (cpu_idx),
        .cpu_nxt (cpu_nxt),
        .lines_o (lines)
    );

    assign bus_req_op    = cpu_op;
    assign cpu_new_state = cpu_nxt;
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mesi_en,
    input logic             cpu_valid,
    input logic             cpu_write,
    input logic             snp_valid,
    input logic [1:0]       snp_op,
    input logic [1:0]       bus_req_op,
    input logic             flush_req,
    input logic [1:0]       cpu_new_state
);
    logic mode_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) mode_seen <= mesi_en;
    end

    // R8
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> snp_valid && (snp_op == 2'd1 || snp_op == 2'd2));

    // R4
    upg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_op == 2'd3 |-> cpu_valid && cpu_write);

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> bus_req_op == 2'd0);

    // R3
    write_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid && cpu_write |-> cpu_new_state == 2'd3);

    // R11
    no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_seen |-> cpu_new_state != 2'd2);
endmodule

bind snoop_coh_ctrl coh_chk #(.IDX_W(IDX_W)) i_coh_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mesi_en       (mesi_en),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .snp_valid     (snp_valid),
    .snp_op        (snp_op),
    .bus_req_op    (bus_req_op),
    .flush_req     (flush_req),
    .cpu_new_state (cpu_new_state)
);

// File: tb/test_snoop_coh_ctrl.sv
`timescale 1ns/1ps
module test_snoop_coh_ctrl;
    localparam int IDX_W = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mesi_en = 1'b0;
    logic cpu_valid = 1'b0, cpu_write = 1'b0, snp_valid = 1'b0, snp_shared_in = 1'b0;
    logic [IDX_W-1:0] cpu_idx = '0, snp_idx = '0;
    logic [1:0] snp_op = 2'd0;
    logic [1:0] bus_req_op, cpu_new_state;
    logic flush_req, shared_out;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    snoop_coh_ctrl i_snoop_coh_ctrl (.*);

    task automatic check(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(logic cv, logic cw, int ci, logic sv, int sop, int si, logic sh);
        @(negedge clk);
        cpu_valid = cv; cpu_write = cw; cpu_idx = IDX_W'(ci);
        snp_valid = sv; snp_op = 2'(sop); snp_idx = IDX_W'(si); snp_shared_in = sh;
        #1;
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        cpu_valid = 0; snp_valid = 0;
        rst_n = 0; mesi_en = mode;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset_state();
        step(0, 0, 5, 0, 0, 0, 0);
        check("R1 idle bus", bus_req_op, 0);
        check("R1 no flush", flush_req, 0);
        check("R12 line invalid", cpu_new_state, 0);
        step(1, 0, 5, 0, 0, 0, 0);
        check("R1 read after reset misses", bus_req_op, 1);
    endtask

    task automatic t_msi_fill();
        step(1, 0, 1, 0, 0, 0, 0);
        check("R2 msi read miss op", bus_req_op, 1);
        check("R11 msi fill shared", cpu_new_state, 1);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R6 read hit S quiet", bus_req_op, 0);
        step(1, 1, 1, 0, 0, 0, 0);
        check("R4 write S upgrade", bus_req_op, 3);
        check("R4 write S to M", cpu_new_state, 3);
        step(1, 1, 1, 0, 0, 0, 0);
        check("R6 write hit M quiet", bus_req_op, 0);
    endtask

    task automatic t_snoop_rd_mod();
        step(0, 0, 1, 1, 1, 1, 0);
        check("R7 flush on M", flush_req, 1);
        check("R7 shared on M", shared_out, 1);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R7 now shared quiet", bus_req_op, 0);
        check("R7 state S", cpu_new_state, 1);
    endtask

    task automatic t_snoop_rdx();
        step(0, 0, 1, 1, 2, 1, 0);
        check("R8 S no flush", flush_req, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R8 S killed", bus_req_op, 1);
        step(1, 1, 2, 0, 0, 0, 0);
        check("R3 write miss op", bus_req_op, 2);
        check("R3 write miss M", cpu_new_state, 3);
        step(0, 0, 2, 1, 2, 2, 0);
        check("R8 M flush", flush_req, 1);
        check("R8 rdx no shared", shared_out, 0);
        step(1, 0, 2, 0, 0, 0, 0);
        check("R8 M killed", bus_req_op, 1);
    endtask

    task automatic t_mesi();
        step(1, 0, 3, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        mesi_en = 0;
        step(1, 0, 4, 0, 0, 0, 0);
        check("R2 mesi fill E", cpu_new_state, 2);
        check("R1 mode held after reset", cpu_new_state, 2);
        step(1, 1, 4, 0, 0, 0, 0);
        check("R5 E write quiet", bus_req_op, 0);
        check("R5 E to M", cpu_new_state, 3);
        step(1, 0, 5, 0, 0, 0, 1);
        check("R2 shared fill S", cpu_new_state, 1);
        step(1, 0, 6, 0, 0, 0, 0);
        step(0, 0, 6, 1, 1, 6, 0);
        check("R7 E shared_out", shared_out, 1);
        check("R7 E no flush", flush_req, 0);
        step(1, 1, 6, 0, 0, 0, 0);
        check("R7 E demoted, write upgrades", bus_req_op, 3);
    endtask

    task automatic t_snoop_upg();
        step(0, 0, 5, 1, 3, 5, 0);
        check("R9 no flush", flush_req, 0);
        step(1, 0, 5, 0, 0, 0, 0);
        check("R9 S killed", bus_req_op, 1);
        step(0, 0, 4, 1, 3, 4, 0);
        step(1, 0, 4, 0, 0, 0, 0);
        check("R9 M untouched op", bus_req_op, 0);
        check("R9 M untouched state", cpu_new_state, 3);
    endtask

    task automatic t_same_cycle();
        step(1, 0, 7, 0, 0, 0, 0);
        step(1, 0, 7, 1, 2, 7, 1);
        check("R10 snoop first then miss", bus_req_op, 1);
        check("R10 refill shared", cpu_new_state, 1);
        step(0, 0, 7, 0, 0, 0, 0);
        check("R12 state kept", cpu_new_state, 1);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_msi_fill();
        t_snoop_rd_mod();
        t_snoop_rdx();
        do_reset(1'b1);
        t_mesi();
        t_snoop_upg();
        t_same_cycle();
        step(0, 0, 0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule